// File: doc/BRIEF.md
# Peripheral Bus Abort Monitor

This block watches the requests a host port issues toward a peripheral bus. It turns any protocol violation into an abort returned to the host. Each request names a peripheral region, a direction and an access width. The block compares the request against two per-region parameter tables: one gives the native width, 8 or 16 bits, and the other gives the permitted direction, read-write, read-only or write-only. A request that breaks either rule is refused. The block then responds with an abort on the next cycle and no peripheral transaction starts.

A legal request opens a transaction that stays in flight until the peripheral acknowledges it. If no acknowledge arrives inside a parameterised window, the block closes the transaction itself and aborts it. The chip-select vector is checked on every cycle. If more than one select is active, the block aborts at once and closes any transaction in flight.

Each cause of abort sets its own sticky bit in a debug flag register. The host clears a bit by writing 1 to it.

Top module: `bus_abort_monitor`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `rsp_done`, `rsp_abort` and all four `dbg_flags` bits are 0.
- R2: A legal request accepted at a clock edge sets `busy`. A `per_ack` sampled at a later edge, inside the window, gives `rsp_done`=1 with `rsp_abort`=0 for one cycle after that edge, and `busy` returns to 0.
- R3: If no acknowledge is sampled within TIMEOUT edges after the accept edge, `rsp_done` and `rsp_abort` both go high one cycle after the TIMEOUT-th edge, and flag bit 0 (timeout) is set. An acknowledge sampled on exactly the TIMEOUT-th edge still completes without abort.
- R4: A request whose width (`hst_wide`: 1 = 16-bit, 0 = 8-bit) differs from the region's entry in RGN_WIDE (bit r = 1 means region r is 16-bit) is answered with `rsp_done` and `rsp_abort` on the next cycle. It sets flag bit 1 and starts no transaction.
- R5: A read of a write-only region or a write (`hst_wr`=1) to a read-only region is answered the same way and sets flag bit 3. RGN_ACC holds two bits per region at [2r+1:2r]: 0 = read-write, 1 = read-only, 2 = write-only. Read-write regions accept both directions.
- R6: Two or more active bits in `hst_cs` on a clock edge give `rsp_done` and `rsp_abort` on the next cycle and set flag bit 2. The collision also ends any transaction in flight, and an acknowledge for that transaction arriving afterwards produces no response.
- R7: `rsp_abort` is never high without `rsp_done`.
- R8: Flag bits are sticky. A cycle with `clr_we`=1 clears each bit set in `clr_mask`. When a bit is set and cleared in the same cycle, the set wins.
- R9: A request presented while `busy` is 1 is ignored: it produces no response and sets no flag.
- R10: A `per_ack` while no transaction is in flight produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Request strobe, one cycle |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| hst_rgn | input | RGN_W | Target region index |
| hst_cs | input | NCS | Chip-select vector |
| per_ack | input | 1 | Peripheral acknowledge |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Write-1-to-clear mask for the flags |
| busy | output | 1 | Transaction in flight |
| rsp_done | output | 1 | Response to host, one cycle per event |
| rsp_abort | output | 1 | Response carries an abort |
| dbg_flags | output | 4 | Sticky causes: 0 timeout, 1 width, 2 chip-select collision, 3 direction |

## Verification
The hardest cases to reach are the ones that depend on exact cycle placement. One is an acknowledge landing on the last edge of the window compared with one edge later. Another is a chip-select collision arriving while a transaction is in flight and followed by a stray acknowledge. The bench drives the acknowledge on a chosen cycle counted from the accept edge and measures the response latency. It also injects collisions, extra requests and flag clears in the middle of open transactions. A scoreboard queue then shows that each event produced exactly one response with the expected abort bit.

// File: rtl/bam_pkg.sv
package bam_pkg;
  localparam int NFLAG   = 4;
  localparam int FLG_TMO = 0;
  localparam int FLG_WID = 1;
  localparam int FLG_CSC = 2;
  localparam int FLG_DIR = 3;

  localparam logic [1:0] ACC_RW = 2'd0;
  localparam logic [1:0] ACC_RO = 2'd1;
  localparam logic [1:0] ACC_WO = 2'd2;
endpackage

// File: rtl/bam_rule_check.sv
module bam_rule_check
  import bam_pkg::*;
#(
  parameter int RGN_W = 3,
  parameter int NCS   = 4,
  parameter logic [(1<<RGN_W)-1:0]   RGN_WIDE = '0,
  parameter logic [2*(1<<RGN_W)-1:0] RGN_ACC  = '0
) (
  input  logic             wr,
  input  logic             wide,
  input  logic [RGN_W-1:0] rgn,
  input  logic [NCS-1:0]   cs,
  output logic             bad_width,
  output logic             bad_dir,
  output logic             cs_collide
);
  logic [1:0] acc;

  always_comb begin
    acc        = RGN_ACC[2*rgn +: 2];
    bad_width  = (wide != RGN_WIDE[rgn]);
    bad_dir    = ((acc == ACC_RO) && wr) || ((acc == ACC_WO) && !wr);
    cs_collide = ($countones(cs) > 1);
  end
endmodule

// File: rtl/bam_watch_timer.sv
module bam_watch_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  input  logic kill,
  output logic busy,
  output logic expire
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;

  assign expire = busy && !ack && !kill && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (ack || kill || expire) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_OPEN_UNTIL_END: assert property (@(posedge clk) disable iff (rst)
    (busy && !ack && !kill && !expire && !start) |=> busy); // R3
  AST_EXPIRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
    expire |=> !busy); // R3
endmodule

// File: rtl/bam_flag_bank.sv
module bam_flag_bank
  import bam_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_eff) | set;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr_eff[i]) |=> flags[i]); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]); // R8
  end
endmodule

// File: rtl/bus_abort_monitor.sv
module bus_abort_monitor
  import bam_pkg::*;
#(
  parameter int TIMEOUT = 64,
  parameter int RGN_W   = 3,
  parameter int NCS     = 4,
  parameter logic [(1<<RGN_W)-1:0]   RGN_WIDE = 8'b0000_1111,
  parameter logic [2*(1<<RGN_W)-1:0] RGN_ACC  = 16'h9900
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hst_req,
  input  logic             hst_wr,
  input  logic             hst_wide,
  input  logic [RGN_W-1:0] hst_rgn,
  input  logic [NCS-1:0]   hst_cs,
  input  logic             per_ack,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_mask,
  output logic             busy,
  output logic             rsp_done,
  output logic             rsp_abort,
  output logic [NFLAG-1:0] dbg_flags
);
  logic bad_width, bad_dir, cs_collide;
  logic accept, refuse, start, expire, ack_ok;
  logic [NFLAG-1:0] set_vec;

  bam_rule_check #(
    .RGN_W(RGN_W), .NCS(NCS), .RGN_WIDE(RGN_WIDE), .RGN_ACC(RGN_ACC)
  ) u_chk (
    .wr(hst_wr), .wide(hst_wide), .rgn(hst_rgn), .cs(hst_cs),
    .bad_width(bad_width), .bad_dir(bad_dir), .cs_collide(cs_collide)
  );

  assign accept = hst_req && !busy && !cs_collide;
  assign refuse = accept && (bad_width || bad_dir);
  assign start  = accept && !bad_width && !bad_dir;
  assign ack_ok = busy && per_ack && !cs_collide;

  bam_watch_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .ack(per_ack), .kill(cs_collide),
    .busy(busy), .expire(expire)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_TMO] = expire;
    set_vec[FLG_WID] = accept && bad_width;
    set_vec[FLG_CSC] = cs_collide;
    set_vec[FLG_DIR] = accept && bad_dir;
  end

  bam_flag_bank u_flg (
    .clk(clk), .rst(rst), .set(set_vec), .clr_we(clr_we),
    .clr_mask(clr_mask), .flags(dbg_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_done  <= 1'b0;
      rsp_abort <= 1'b0;
    end else begin
      rsp_done  <= cs_collide || refuse || expire || ack_ok;
      rsp_abort <= cs_collide || refuse || expire;
    end
  end

  AST_ABORT_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
    rsp_abort |-> rsp_done); // R7
  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> !busy); // R2
  AST_COLLIDE_ABORTS: assert property (@(posedge clk) disable iff (rst)
    cs_collide |=> (rsp_abort && dbg_flags[FLG_CSC])); // R6
  AST_TMO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    expire |=> (rsp_abort && dbg_flags[FLG_TMO])); // R3
  AST_IDLE_ACK_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!busy && per_ack && !hst_req && !cs_collide) |=> !rsp_done); // R10
  AST_BUSY_REQ_NOFLAG: assert property (@(posedge clk) disable iff (rst)
    (busy && hst_req && !dbg_flags[FLG_WID] && !(clr_we && clr_mask[FLG_WID]))
      |=> !dbg_flags[FLG_WID]); // R9
endmodule

// File: tb/sim_bus_abort_monitor.sv
module sim_bus_abort_monitor;
  localparam int LIM = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hst_req = 0, hst_wr = 0, hst_wide = 0, per_ack = 0, clr_we = 0;
  logic [2:0] hst_rgn = '0;
  logic [3:0] hst_cs = '0;
  logic [3:0] clr_mask = '0;
  logic busy, rsp_done, rsp_abort;
  logic [3:0] dbg_flags;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_abort_monitor #(.TIMEOUT(LIM)) u0 (
    .clk(clk), .rst(rst), .hst_req(hst_req), .hst_wr(hst_wr),
    .hst_wide(hst_wide), .hst_rgn(hst_rgn), .hst_cs(hst_cs),
    .per_ack(per_ack), .clr_we(clr_we), .clr_mask(clr_mask),
    .busy(busy), .rsp_done(rsp_done), .rsp_abort(rsp_abort),
    .dbg_flags(dbg_flags)
  );

  // Monitor: every response must match the next expected item (R7, R9, R10)
  always @(negedge clk) begin
    if (!rst && rsp_done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9/R10 unexpected response: abort=%0b expected none", rsp_abort);
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (rsp_abort !== e) begin
          errors++;
          $display("FAIL R2-abort-bit response: abort=%0b expected %0b", rsp_abort, e);
        end
      end
    end
    if (!rst && rsp_abort && !rsp_done) begin
      checks++; errors++;
      $display("FAIL R7 abort without done: done=%0b expected 1", rsp_done);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue one request; ack on cycle d after the request cycle (0 = never).
  task automatic xact(input string tag, input logic [2:0] rgn, input logic wr,
                      input logic wide, input int d, input bit exp_ab, input int exp_lat);
    int lat = 0;
    exp_q.push_back(exp_ab);
    @(negedge clk);
    hst_req = 1; hst_rgn = rgn; hst_wr = wr; hst_wide = wide;
    hst_cs = 4'b0001 << rgn[1:0];
    for (int k = 1; k <= LIM + 4; k++) begin
      @(negedge clk);
      hst_req = 0; hst_cs = '0;
      if (rsp_done && lat == 0) lat = k;
      per_ack = (k == d);
    end
    per_ack = 0;
    check({tag, " latency"}, lat, exp_lat);
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk);
    clr_we = 1; clr_mask = m;
    @(negedge clk);
    clr_we = 0; clr_mask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", rsp_done, 0);
    check("R1 abort", rsp_abort, 0);
    check("R1 flags", dbg_flags, 0);

    // R2: legal accesses completed by the peripheral
    xact("R2 rgn0 wr16", 3'd0, 1, 1, 3, 0, 4);
    xact("R2 rgn2 rd16", 3'd2, 0, 1, 1, 0, 2);
    check("R2 flags clean", dbg_flags, 0);

    // R3: timeout, and ack on the very last allowed edge
    xact("R3 timeout", 3'd1, 0, 1, 0, 1, LIM + 1);
    check("R3 timeout flag", dbg_flags, 4'b0001);
    clear(4'b0001);
    check("R8 w1c clears", dbg_flags, 0);
    xact("R3 ack last edge", 3'd3, 1, 1, LIM, 0, LIM + 1);
    check("R3 last-edge no flag", dbg_flags, 0);
    // R10: ack one edge too late is ignored
    xact("R3 ack too late", 3'd3, 1, 1, LIM + 1, 1, LIM + 1);
    check("R3 late flag", dbg_flags, 4'b0001);
    clear(4'b1111);

    // R4: width mismatch
    xact("R4 narrow to 16b", 3'd0, 1, 0, 2, 1, 1);
    check("R4 width flag", dbg_flags, 4'b0010);
    check("R4 no transaction", busy, 0);
    // R5: direction rules
    xact("R5 write RO", 3'd4, 1, 0, 2, 1, 1);
    check("R5 dir flag + sticky R8", dbg_flags, 4'b1010);
    clear(4'b1010);
    xact("R5 read WO", 3'd5, 0, 0, 2, 1, 1);
    check("R5 WO read flag", dbg_flags, 4'b1000);
    xact("R5 write WO ok", 3'd5, 1, 0, 2, 0, 3);
    xact("R5 read RO ok", 3'd6, 0, 0, 1, 0, 2);
    xact("R5 both bad", 3'd7, 0, 1, 1, 1, 1);
    check("R5 width+dir flags", dbg_flags, 4'b1010);
    clear(4'b1111);

    // R6: collision while idle
    exp_q.push_back(1);
    @(negedge clk); hst_cs = 4'b0101;
    @(negedge clk); hst_cs = '0;
    check("R6 idle collision done", rsp_done, 1);
    @(negedge clk);
    check("R6 collision flag", dbg_flags, 4'b0100);
    clear(4'b0100);

    // R6 + R10: collision ends an open transaction, later ack ignored
    exp_q.push_back(1);
    @(negedge clk); hst_req = 1; hst_rgn = 3'd0; hst_wr = 1; hst_wide = 1;
    @(negedge clk); hst_req = 0;
    check("R6 open busy", busy, 1);
    @(negedge clk); hst_cs = 4'b1100;
    @(negedge clk); hst_cs = '0;
    check("R6 busy cut", busy, 0);
    @(negedge clk); per_ack = 1;
    @(negedge clk); per_ack = 0;
    repeat (3) @(negedge clk);
    check("R6 flags", dbg_flags, 4'b0100);
    clear(4'b0100);

    // R9: request while busy is ignored
    exp_q.push_back(0);
    @(negedge clk); hst_req = 1; hst_rgn = 3'd1; hst_wr = 0; hst_wide = 1;
    @(negedge clk); hst_req = 0;
    @(negedge clk); hst_req = 1; hst_rgn = 3'd0; hst_wide = 0;
    @(negedge clk); hst_req = 0;
    @(negedge clk); per_ack = 1;
    @(negedge clk); per_ack = 0;
    repeat (3) @(negedge clk);
    check("R9 busy req no flag", dbg_flags, 0);

    // R8: set wins over clear in the same cycle
    exp_q.push_back(1);
    @(negedge clk); hst_req = 1; hst_rgn = 3'd2; hst_wr = 1; hst_wide = 0;
    clr_we = 1; clr_mask = 4'b0010;
    @(negedge clk); hst_req = 0; clr_we = 0; clr_mask = '0;
    @(negedge clk);
    check("R8 set beats clear", dbg_flags, 4'b0010);

    // R10: ack while idle
    @(negedge clk); per_ack = 1;
    @(negedge clk); per_ack = 0;
    repeat (3) @(negedge clk);
    check("R10 idle ack flags", dbg_flags, 4'b0010);

    check("scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule